// File: doc/BRIEF.md
# Byte-Serial Transmitter with Buffer Flags

This block turns bytes into asynchronous serial frames on one output line. Software writes a byte into a one-entry holding buffer through a small register port. When the line is free and the next bit-rate enable pulse arrives, the byte moves into a shift register. The frame goes out with the most significant bit first. It has a low start bit, the data bits, an optional parity bit and a high stop bit. Each bit lasts one period of the bit-rate enable. The buffer is free again as soon as its byte has moved, so the next byte can be queued while the current frame is still on the line.

Two status bits report progress. The busy bit shows that the shift register is sending a frame. The empty bit is set each time a byte leaves the buffer, and it drives the interrupt output. Software clears the empty bit by writing a 1 to its position. The bit-rate enable comes from outside; the block has no baud-rate divider.

The shifter is a five-state machine: IDLE (line high), START (line low), DATA (one state per byte, counting the bits), PARITY and STOP (line high). It has these transitions:

- IDLE to START on an enable pulse when the buffer holds a byte.
- START to DATA on the next pulse.
- DATA to PARITY, or to STOP when parity is off, on the pulse that ends the last data bit.
- PARITY to STOP on a pulse.
- STOP to START on a pulse when the buffer holds a byte, otherwise STOP to IDLE.

Register map:

| Address | Register | Access | Bits |
|---|---|---|---|
| 0 | transmit data | write | the byte to send; reads as 0 |
| 1 | configuration | read/write | bit0 = parity enable, bit1 = odd parity |
| 2 | status | read, write-1-to-clear | bit0 = busy, bit1 = buffer empty |

Top module: `uart_msb_tx`

## Requirements
- R1: After reset, `tx_out` is 1, status reads 0 (busy 0, empty 0) and `irq` is 0.
- R2: A frame is a 0 start bit, then the eight data bits with bit 7 first, then a 1 stop bit. Each bit lasts exactly one `bit_tick` period.
- R3: When configuration bit0 is 1, one parity bit follows bit 0 of the data and comes before the stop bit. With configuration bit1 = 0 the parity is even: the parity bit plus the data bits hold an even number of ones. With bit1 = 1 the parity is odd.
- R4: When configuration bit0 is 0, the stop bit follows the last data bit directly.
- R5: Status bit0 (busy) is 1 from the start bit through the stop bit and is 0 once the line is idle.
- R6: Status bit1 (empty) becomes 1 when the buffered byte moves into the shift register, and `irq` equals this bit.
- R7: A write to address 2 with bit1 = 1 clears the empty bit. A write with bit1 = 0 leaves it unchanged. No other action clears it.
- R8: A byte written while a frame is being sent starts with its start bit in the bit period right after that frame's stop bit, with no idle bit in between.
- R9: A write to address 0 while the buffer already holds a byte is ignored. The empty bit stays 0 until the held byte is consumed.
- R10: A byte moves out of the buffer only on a `bit_tick` cycle, so busy stays 0 between the write and the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bit_tick | input | 1 | one-cycle pulse per bit period |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 2 | register address for both reads and writes |
| reg_wdata | input | 8 | register write data |
| reg_rdata | output | 8 | register read data (combinational) |
| tx_out | output | 1 | serial output line |
| irq | output | 1 | interrupt request, equal to the empty bit |

## Verification
The assertions check these points on every cycle:

- The shifter changes state only on an enable pulse.
- A hand-off always lands in START, including the back-to-back path out of STOP.
- The held byte never changes while a write hits a full buffer.
- The empty bit sets on hand-off and clears on a write-1.

Only the bench's scenarios can show the following, because they need a decoder of the whole line:

- The bit order and the parity value for each setting.
- That the frame has no gap when two bytes are queued.
- That a discarded byte never appears on the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CFG_PAR_EN  = 0;
    localparam int CFG_PAR_ODD = 1;
    localparam int STAT_BUSY   = 0;
    localparam int STAT_EMPTY  = 1;

endpackage

// File: rtl/utx_holding_buf.sv
module utx_holding_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [DATA_W-1:0] load_data,
    input  logic              clr_stb,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] held,
    output logic              empty_flag
);

    // Holding register. A write that arrives while full is dropped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            held <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (load_stb && !full) begin
            full <= 1'b1;
            held <= load_data;
        end
    end

    // Empty flag: set on hand-off, cleared only by a write-1. Set wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_flag <= 1'b0;
        end else if (take) begin
            empty_flag <= 1'b1;
        end else if (clr_stb) begin
            empty_flag <= 1'b0;
        end
    end

    a_r9_full_write_ignored: assert property (
        @(posedge clk) disable iff (!rst_n)
        (load_stb && full) |=> $stable(held)
    );

    a_r6_flag_on_take: assert property (
        @(posedge clk) disable iff (!rst_n)
        take |=> empty_flag
    );

    a_r7_w1c_clears: assert property (
        @(posedge clk) disable iff (!rst_n)
        (clr_stb && !take) |=> !empty_flag
    );

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              take,
    output logic              busy,
    output logic              tx_out
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_state_t         state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              par_bit;
    logic              par_on;

    // A byte is taken on a pulse when the line is idle or a stop bit ends.
    always_comb begin
        take = bit_tick && buf_full && ((state == ST_IDLE) || (state == ST_STOP));
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        if (bit_tick) begin
            unique case (state)
                ST_IDLE:   state_nx = buf_full ? ST_START : ST_IDLE;
                ST_START:  state_nx = ST_DATA;
                ST_DATA:   if (bit_cnt == LAST_BIT) state_nx = par_on ? ST_PARITY : ST_STOP;
                ST_PARITY: state_nx = ST_STOP;
                ST_STOP:   state_nx = buf_full ? ST_START : ST_IDLE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Datapath: shift register, bit counter, parity.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            par_bit <= 1'b0;
            par_on  <= 1'b0;
        end else if (take) begin
            shreg   <= buf_data;
            bit_cnt <= '0;
            par_bit <= (^buf_data) ^ par_odd;
            par_on  <= par_en;
        end else if (bit_tick && state == ST_DATA) begin
            shreg   <= {shreg[DATA_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Output process.
    always_comb begin
        busy   = (state != ST_IDLE);
        tx_out = 1'b1;
        unique case (state)
            ST_IDLE:   tx_out = 1'b1;
            ST_START:  tx_out = 1'b0;
            ST_DATA:   tx_out = shreg[DATA_W-1];
            ST_PARITY: tx_out = par_bit;
            ST_STOP:   tx_out = 1'b1;
            default:   tx_out = 1'b1;
        endcase
    end

    a_r10_move_on_tick: assert property (
        @(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(state)
    );

    a_r2_take_starts_frame: assert property (
        @(posedge clk) disable iff (!rst_n)
        take |=> (state == ST_START)
    );

    a_r8_back_to_back: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && bit_tick && buf_full) |=> (state == ST_START)
    );

    a_r5_idle_line_high: assert property (
        @(posedge clk) disable iff (!rst_n)
        !busy |-> tx_out
    );

endmodule

// File: rtl/uart_msb_tx.sv
module uart_msb_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_out,
    output logic              irq
);

    logic              cfg_par_en, cfg_par_odd;
    logic              load_stb, clr_stb;
    logic              take, full, busy, empty_flag;
    logic [DATA_W-1:0] held;

    always_comb begin
        load_stb = reg_wr && (reg_addr == ADDR_DATA);
        clr_stb  = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[STAT_EMPTY];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_par_en  <= 1'b0;
            cfg_par_odd <= 1'b0;
        end else if (reg_wr && reg_addr == ADDR_CFG) begin
            cfg_par_en  <= reg_wdata[CFG_PAR_EN];
            cfg_par_odd <= reg_wdata[CFG_PAR_ODD];
        end
    end

    utx_holding_buf #(.DATA_W(DATA_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_stb   (load_stb),
        .load_data  (reg_wdata),
        .clr_stb    (clr_stb),
        .take       (take),
        .full       (full),
        .held       (held),
        .empty_flag (empty_flag)
    );

    utx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .buf_full (full),
        .buf_data (held),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .take     (take),
        .busy     (busy),
        .tx_out   (tx_out)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CFG: begin
                reg_rdata[CFG_PAR_EN]  = cfg_par_en;
                reg_rdata[CFG_PAR_ODD] = cfg_par_odd;
            end
            ADDR_STAT: begin
                reg_rdata[STAT_BUSY]  = busy;
                reg_rdata[STAT_EMPTY] = empty_flag;
            end
            default: reg_rdata = '0;
        endcase
        irq = empty_flag;
    end

    a_r6_irq_follows_flag: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(take)
    );

endmodule

// File: tb/uart_msb_tx_test.sv
module uart_msb_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int NVEC       = 6;
    localparam int WATCHDOG   = 100000;

    // Each vector: {data[7:0], parity enable, odd parity}.
    localparam logic [9:0] VECS [NVEC] = '{
        {8'hA5, 1'b0, 1'b0},
        {8'h80, 1'b1, 1'b0},
        {8'h01, 1'b1, 1'b1},
        {8'hFF, 1'b1, 1'b0},
        {8'h00, 1'b1, 1'b1},
        {8'h3C, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       tx_out, irq;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   tb_pe = 1'b0;

    // Line decoder state.
    int         ph = 0, nb = 0, gap = 0, rx_cnt = 0;
    logic [7:0] shv = 8'd0;
    logic       pbit = 1'b0;
    logic [7:0] rx_data [32];
    logic       rx_par  [32];
    logic       rx_stop [32];
    int         rx_gap  [32];

    uart_msb_tx uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_out(tx_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bit-rate pulse: one cycle in every TICK_DIV, changed at the rising edge.
    initial begin
        @(posedge rst_n);
        forever begin
            repeat (TICK_DIV - 1) @(posedge clk);
            bit_tick <= 1'b1;
            @(posedge clk);
            bit_tick <= 1'b0;
        end
    end

    // Decoder: sample the line in the last cycle of each bit period.
    always @(negedge clk) begin
        if (rst_n && bit_tick) begin
            case (ph)
                0: if (!tx_out) begin ph = 1; nb = 0; shv = 8'd0; end
                   else gap = gap + 1;
                1: begin
                    shv = {shv[6:0], tx_out};
                    nb = nb + 1;
                    if (nb == 8) ph = tb_pe ? 2 : 3;
                end
                2: begin pbit = tx_out; ph = 3; end
                default: begin
                    if (rx_cnt < 32) begin
                        rx_data[rx_cnt] = shv;
                        rx_par[rx_cnt]  = pbit;
                        rx_stop[rx_cnt] = tx_out;
                        rx_gap[rx_cnt]  = gap;
                    end
                    rx_cnt = rx_cnt + 1;
                    gap = 0;
                    ph = 0;
                end
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_frames(input int n);
        for (int i = 0; i < 2000 && rx_cnt < n; i++) @(negedge clk);
    endtask

    task automatic wait_tick_seen();
        do @(negedge clk); while (!bit_tick);
    endtask

    // Watchdog.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int base;
        repeat (3) @(negedge clk);

        // R1: reset state.
        reg_read(2'd2, v);
        check(tx_out == 1'b1, "R1 tx idle", tx_out, 1);
        check(v == 8'h00, "R1 status", v, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table: R2 frame order, R3 parity, R4 no parity, R6 flag.
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] d;
            logic pe, od;
            {d, pe, od} = VECS[i];
            reg_write(2'd1, {6'd0, od, pe});
            tb_pe = pe;
            base = rx_cnt;
            reg_write(2'd0, d);
            wait_frames(base + 1);
            check(rx_data[base] == d, "R2 data MSB first", rx_data[base], d);
            check(rx_stop[base] == 1'b1, "R2 stop bit", rx_stop[base], 1);
            if (pe)
                check(rx_par[base] == ((^d) ^ od), "R3 parity", rx_par[base], (^d) ^ od);
            else
                check(rx_cnt == base + 1, "R4 no parity frame", rx_cnt, base + 1);
            check(irq == 1'b1, "R6 irq after hand-off", irq, 1);
            reg_write(2'd2, 8'h02);
        end

        // R7: write-0 keeps flag, write-1 clears it.
        base = rx_cnt;
        reg_write(2'd0, 8'h96);
        wait_frames(base + 1);
        reg_write(2'd2, 8'h01);
        check(irq == 1'b1, "R7 write0 keeps flag", irq, 1);
        reg_write(2'd2, 8'h02);
        reg_read(2'd2, v);
        check(irq == 1'b0, "R7 write1 clears irq", irq, 0);
        check(v[1] == 1'b0, "R7 status empty bit", v[1], 0);

        // R10 and R5: no hand-off before the next pulse; busy during frame.
        tb_pe = 1'b0;
        reg_write(2'd1, 8'h00);
        wait_tick_seen();
        base = rx_cnt;
        reg_write(2'd0, 8'h5A);
        reg_read(2'd2, v);
        check(v[0] == 1'b0, "R10 busy before pulse", v[0], 0);
        check(tx_out == 1'b1, "R10 line idle before pulse", tx_out, 1);
        wait_tick_seen();
        @(negedge clk);
        reg_read(2'd2, v);
        check(v[0] == 1'b1, "R5 busy during frame", v[0], 1);
        check(irq == 1'b1, "R6 flag at hand-off", irq, 1);

        // R8 and R9: queue a second byte, then a third that must be dropped.
        reg_write(2'd0, 8'hC3);
        reg_write(2'd2, 8'h02);
        reg_write(2'd0, 8'h77);
        reg_read(2'd2, v);
        check(irq == 1'b0, "R9 flag stays clear while full", irq, 0);
        check(v[1] == 1'b0, "R9 status empty bit", v[1], 0);
        wait_frames(base + 2);
        check(rx_data[base] == 8'h5A, "R8 first frame", rx_data[base], 8'h5A);
        check(rx_data[base+1] == 8'hC3, "R8 second frame", rx_data[base+1], 8'hC3);
        check(rx_gap[base+1] == 0, "R8 no idle gap", rx_gap[base+1], 0);
        check(irq == 1'b1, "R9 flag after consume", irq, 1);
        repeat (TICK_DIV * 14) @(negedge clk);
        check(rx_cnt == base + 2, "R9 dropped byte not sent", rx_cnt, base + 2);
        reg_read(2'd2, v);
        check(v[0] == 1'b0, "R5 busy clear when idle", v[0], 0);
        check(tx_out == 1'b1, "R5 line idle", tx_out, 1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule